// File: doc/BRIEF.md
# Double-Buffered SPI Master Transceiver

This block is an SPI master that moves one word in each direction at a time. The host writes a word into a one-entry transmit holding register. The shift engine takes that word as soon as it is free, clocks it out on `mosi` and collects the same number of bits from `miso`. A completed word lands in a one-entry receive holding register. To read from a slave, the host writes any filler value, because the write is what starts the clocking. Slave select is not part of this block; logic outside it drives slave select around a run of words.

Two flags report the state of the holding registers. `tx_empty` says the transmit register can take a word. `rx_full` says a captured word is waiting. Each flag drives a maskable interrupt line and a separately enabled one-cycle DMA request. The request fires when its flag rises, so a DMA channel can feed the transmit side or drain the receive side without software.

The engine takes the next word at the final falling clock edge of the current one. A write that arrives before that edge therefore gives a gap-free stream. A later write leaves the bus idle between words. If a word completes while the receive register is still full, the new word is dropped and an overrun flag is raised. The word length (2 to 16 bits), the bit order and the SPI clock divider are set by inputs. The SPI clock runs in mode 0: it idles low and data is sampled on the rising edge.

Top module: `spi_xcvr_master`

## Requirements
- R1: After reset, `tx_empty` is 1. `rx_full`, `rx_overrun`, `busy`, `sclk`, both request lines and both interrupt lines are 0.
- R2: A `tx_wr` pulse while `tx_empty` is 1 stores `tx_data` and starts a transfer, whatever the value written. `tx_empty` goes low and rises again when the word moves into the shift register. A `tx_wr` while `tx_empty` is 0 is ignored, and that word is never shifted out.
- R3: `sclk` is low whenever `busy` is low. `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge. Every high phase and low phase of `sclk` inside a transfer lasts `cfg_div`+1 clock cycles.
- R4: `cfg_len` sets the word length from 2 to 16 bits. Exactly that many `sclk` rising edges occur per word, and only the low `cfg_len` bits of `tx_data` are sent.
- R5: With `cfg_lsb_first` = 0 the most significant of the `cfg_len` bits is sent and received first. With 1 the least significant bit goes first. The received word is right-justified in `rx_data`.
- R6: When a word completes and the receive register is free, `rx_data` takes the word and `rx_full` goes to 1. `rx_full` stays 1 until an `rx_rd` pulse clears it.
- R7: If a word completes while `rx_full` is 1 and no `rx_rd` is present, `rx_overrun` goes to 1 and `rx_data` keeps the old word. `rx_rd` clears both `rx_full` and `rx_overrun`.
- R8: A word written before the final falling edge of the word in flight follows it with no idle time. `busy` stays high and the `sclk` phases keep their length across the boundary.
- R9: If no word is waiting at the final falling edge, `busy` drops and `sclk` stays low until the next write.
- R10: `tx_dreq` is a one-cycle pulse in the cycle that `tx_empty` rises, given `tx_dma_en` was 1 in the cycle before. It is never high otherwise.
- R11: `rx_dreq` is a one-cycle pulse in the cycle that `rx_full` rises, given `rx_dma_en` was 1 in the cycle before. It is never high otherwise.
- R12: `tx_irq` equals `tx_empty` ANDed with the previous cycle's `tx_irq_en`. `rx_irq` equals (`rx_full` OR `rx_overrun`) ANDed with the previous cycle's `rx_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_len | input | 5 | Word length in bits, 2 to 16 |
| cfg_div | input | 8 | SPI clock half period minus one, in system clocks |
| cfg_lsb_first | input | 1 | 1 selects least significant bit first |
| tx_irq_en | input | 1 | Mask for the transmit interrupt |
| rx_irq_en | input | 1 | Mask for the receive interrupt |
| tx_dma_en | input | 1 | Enables transmit DMA requests |
| rx_dma_en | input | 1 | Enables receive DMA requests |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_data | input | 16 | Word to transmit |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_data | output | 16 | Last received word, right-justified |
| tx_empty | output | 1 | Transmit register can take a word |
| rx_full | output | 1 | Receive register holds an unread word |
| rx_overrun | output | 1 | A word was lost because the receive register was full |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| tx_dreq | output | 1 | Transmit DMA request pulse |
| rx_dreq | output | 1 | Receive DMA request pulse |
| busy | output | 1 | A word is being shifted |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The divider-range assertion assumes `cfg_div` does not change while `busy` is high. The length and order settings are likewise assumed to change only between transfers. The stimulus rewrites these inputs only after `busy` has fallen and the transmit register is empty. The serial slave model changes `miso` only after it has seen an `sclk` rising edge, so the sampled bit is always stable before the edge.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  localparam int MIN_BITS = 2;

  typedef enum logic {
    ORD_MSB = 1'b0,
    ORD_LSB = 1'b1
  } bit_order_e;

  function automatic int clamp_len(int raw, int max_bits);
    if (raw < MIN_BITS) return MIN_BITS;
    if (raw > max_bits) return max_bits;
    return raw;
  endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run && $stable(half_div) |-> cnt_q <= half_div); // R3

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_xcvr_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int DIV_W    = 8,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                cfg_lsb_first,
  input  logic                buf_full,
  input  logic [MAX_BITS-1:0] buf_data,
  input  logic                miso,
  output logic                take,
  output logic                busy,
  output logic                sclk,
  output logic                mosi,
  output logic                word_done,
  output logic [MAX_BITS-1:0] rx_word
);

  logic                tick;
  logic                busy_q, sclk_q, mosi_q, done_q;
  logic [MAX_BITS-1:0] tsh_q, rsh_q, word_q;
  logic [LEN_W-1:0]    left_q, len_q;
  bit_order_e          ord_q;

  logic [LEN_W-1:0]    eff_len;
  logic [MAX_BITS-1:0] aligned;
  logic [MAX_BITS-1:0] assembled;
  logic                last_fall;

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (busy_q),
    .half_div (cfg_div),
    .tick     (tick)
  );

  always_comb begin
    eff_len = LEN_W'(clamp_len(int'(cfg_len), MAX_BITS));
    if (cfg_lsb_first) aligned = buf_data;
    else               aligned = buf_data << (MAX_BITS - int'(eff_len));
    if (ord_q == ORD_LSB)
      assembled = rsh_q >> (MAX_BITS - int'(len_q));
    else
      assembled = rsh_q & ({MAX_BITS{1'b1}} >> (MAX_BITS - int'(len_q)));
  end

  assign last_fall = busy_q && tick && sclk_q && (left_q == LEN_W'(1));
  assign take      = buf_full && (!busy_q || last_fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      tsh_q  <= '0;
      rsh_q  <= '0;
      word_q <= '0;
      left_q <= '0;
      len_q  <= LEN_W'(MIN_BITS);
      ord_q  <= ORD_MSB;
    end else begin
      done_q <= last_fall;
      if (last_fall) word_q <= assembled;
      if (take) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        tsh_q  <= aligned;
        mosi_q <= cfg_lsb_first ? aligned[0] : aligned[MAX_BITS-1];
        rsh_q  <= '0;
        left_q <= eff_len;
        len_q  <= eff_len;
        ord_q  <= cfg_lsb_first ? ORD_LSB : ORD_MSB;
      end else if (busy_q && tick) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          if (ord_q == ORD_LSB) rsh_q <= {miso, rsh_q[MAX_BITS-1:1]};
          else                  rsh_q <= {rsh_q[MAX_BITS-2:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (left_q == LEN_W'(1)) begin
            busy_q <= 1'b0;
          end else begin
            left_q <= left_q - 1'b1;
            if (ord_q == ORD_LSB) begin
              tsh_q  <= tsh_q >> 1;
              mosi_q <= tsh_q[1];
            end else begin
              tsh_q  <= tsh_q << 1;
              mosi_q <= tsh_q[MAX_BITS-2];
            end
          end
        end
      end
    end
  end

  assign busy      = busy_q;
  assign sclk      = sclk_q;
  assign mosi      = mosi_q;
  assign word_done = done_q;
  assign rx_word   = word_q;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !sclk_q); // R3
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> $stable(mosi_q)); // R3
  AST_LEFT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (left_q >= LEN_W'(1)) && (int'(left_q) <= MAX_BITS)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R6

endmodule

// File: rtl/spi_xfer_buffers.sv
module spi_xfer_buffers #(
  parameter int MAX_BITS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_wr,
  input  logic [MAX_BITS-1:0] tx_data,
  input  logic                take,
  input  logic                rx_rd,
  input  logic                word_done,
  input  logic [MAX_BITS-1:0] rx_word,
  input  logic                tx_dma_en,
  input  logic                rx_dma_en,
  input  logic                tx_irq_en,
  input  logic                rx_irq_en,
  output logic                buf_full,
  output logic [MAX_BITS-1:0] buf_data,
  output logic                tx_empty,
  output logic                rx_full,
  output logic                rx_overrun,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                tx_dreq,
  output logic                rx_dreq,
  output logic                tx_irq,
  output logic                rx_irq
);

  logic                txe_q, txe_d, rxf_q, rxf_d, ovr_q, ovr_d;
  logic                wr_ok, slot_free, store;
  logic [MAX_BITS-1:0] txbuf_q, rxbuf_q;
  logic                txdr_q, rxdr_q, txirq_q, rxirq_q;

  always_comb begin
    wr_ok = tx_wr && txe_q;
    txe_d = txe_q;
    if (take)       txe_d = 1'b1;
    else if (wr_ok) txe_d = 1'b0;

    slot_free = !rxf_q || rx_rd;
    store     = word_done && slot_free;

    rxf_d = rxf_q;
    if (store)      rxf_d = 1'b1;
    else if (rx_rd) rxf_d = 1'b0;

    ovr_d = ovr_q;
    if (word_done && !slot_free) ovr_d = 1'b1;
    else if (rx_rd)              ovr_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txe_q   <= 1'b1;
      rxf_q   <= 1'b0;
      ovr_q   <= 1'b0;
      txbuf_q <= '0;
      rxbuf_q <= '0;
      txdr_q  <= 1'b0;
      rxdr_q  <= 1'b0;
      txirq_q <= 1'b0;
      rxirq_q <= 1'b0;
    end else begin
      txe_q   <= txe_d;
      rxf_q   <= rxf_d;
      ovr_q   <= ovr_d;
      if (wr_ok) txbuf_q <= tx_data;
      if (store) rxbuf_q <= rx_word;
      txdr_q  <= tx_dma_en && txe_d && !txe_q;
      rxdr_q  <= rx_dma_en && rxf_d && !rxf_q;
      txirq_q <= tx_irq_en && txe_d;
      rxirq_q <= rx_irq_en && (rxf_d || ovr_d);
    end
  end

  assign buf_full   = !txe_q;
  assign buf_data   = txbuf_q;
  assign tx_empty   = txe_q;
  assign rx_full    = rxf_q;
  assign rx_overrun = ovr_q;
  assign rx_data    = rxbuf_q;
  assign tx_dreq    = txdr_q;
  assign rx_dreq    = rxdr_q;
  assign tx_irq     = txirq_q;
  assign rx_irq     = rxirq_q;

  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !txe_q && tx_wr && !take |=> $stable(txbuf_q)); // R2
  AST_RXF_STICKY: assert property (@(posedge clk) disable iff (rst)
    rxf_q && !rx_rd |=> rxf_q); // R6
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    rxf_q && !rx_rd && word_done |=> $stable(rxbuf_q) && ovr_q); // R7
  AST_TX_DREQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    txdr_q |-> $rose(txe_q) && $past(tx_dma_en)); // R10
  AST_RX_DREQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    rxdr_q |-> $rose(rxf_q) && $past(rx_dma_en)); // R11

endmodule

// File: rtl/spi_xcvr_master.sv
module spi_xcvr_master
  import spi_xcvr_pkg::*;
#(
  parameter int  MAX_BITS = 16,
  parameter int  DIV_W    = 8,
  localparam int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                cfg_lsb_first,
  input  logic                tx_irq_en,
  input  logic                rx_irq_en,
  input  logic                tx_dma_en,
  input  logic                rx_dma_en,
  input  logic                tx_wr,
  input  logic [MAX_BITS-1:0] tx_data,
  input  logic                rx_rd,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                tx_empty,
  output logic                rx_full,
  output logic                rx_overrun,
  output logic                tx_irq,
  output logic                rx_irq,
  output logic                tx_dreq,
  output logic                rx_dreq,
  output logic                busy,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso
);

  logic                take, buf_full, word_done;
  logic [MAX_BITS-1:0] buf_data, rx_word;

  spi_xfer_buffers #(.MAX_BITS(MAX_BITS)) u_buf (
    .clk        (clk),
    .rst        (rst),
    .tx_wr      (tx_wr),
    .tx_data    (tx_data),
    .take       (take),
    .rx_rd      (rx_rd),
    .word_done  (word_done),
    .rx_word    (rx_word),
    .tx_dma_en  (tx_dma_en),
    .rx_dma_en  (rx_dma_en),
    .tx_irq_en  (tx_irq_en),
    .rx_irq_en  (rx_irq_en),
    .buf_full   (buf_full),
    .buf_data   (buf_data),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun),
    .rx_data    (rx_data),
    .tx_dreq    (tx_dreq),
    .rx_dreq    (rx_dreq),
    .tx_irq     (tx_irq),
    .rx_irq     (rx_irq)
  );

  spi_shift_engine #(
    .MAX_BITS (MAX_BITS),
    .DIV_W    (DIV_W),
    .LEN_W    (LEN_W)
  ) u_eng (
    .clk           (clk),
    .rst           (rst),
    .cfg_len       (cfg_len),
    .cfg_div       (cfg_div),
    .cfg_lsb_first (cfg_lsb_first),
    .buf_full      (buf_full),
    .buf_data      (buf_data),
    .miso          (miso),
    .take          (take),
    .busy          (busy),
    .sclk          (sclk),
    .mosi          (mosi),
    .word_done     (word_done),
    .rx_word       (rx_word)
  );

  AST_TAKE_FROM_IDLE_OR_END: assert property (@(posedge clk) disable iff (rst)
    take |=> busy && tx_empty); // R2

endmodule

// File: tb/test_spi_xcvr_master.sv
module test_spi_xcvr_master;

  localparam int MAXB = 16;
  localparam int DW   = 8;
  localparam int LW   = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [LW-1:0]   cfg_len = 5'd8;
  logic [DW-1:0]   cfg_div = '0;
  logic            cfg_lsb = 1'b0;
  logic            tx_ie = 1'b0, rx_ie = 1'b0, tx_de = 1'b0, rx_de = 1'b0;
  logic            tx_wr = 1'b0, rx_rd = 1'b0, miso = 1'b0;
  logic [MAXB-1:0] tx_data = '0;
  logic [MAXB-1:0] rx_data;
  logic            txe, rxf, ovr, tx_irq, rx_irq, tx_dreq, rx_dreq, busy, sclk, mosi;

  spi_xcvr_master i_spi_xcvr_master (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_div(cfg_div),
    .cfg_lsb_first(cfg_lsb), .tx_irq_en(tx_ie), .rx_irq_en(rx_ie),
    .tx_dma_en(tx_de), .rx_dma_en(rx_de), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .tx_empty(txe), .rx_full(rxf),
    .rx_overrun(ovr), .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_dreq(tx_dreq),
    .rx_dreq(rx_dreq), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int ph = 0, busy_falls = 0, txd_cnt = 0, rxd_cnt = 0;
  bit meas = 1'b0;
  bit sq[$];
  bit mq[$];
  logic sclk_p = 1'b0, busy_p = 1'b0, txe_p = 1'b1, rxf_p = 1'b0;
  logic txde_p = 1'b0, rxde_p = 1'b0, txie_p = 1'b0, rxie_p = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // reference model of the serial slave and flag/request timing, every clock
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(busy || !sclk, "R3 sclk idle low", sclk, 0);
      chk(tx_dreq == (txe && !txe_p && txde_p), "R10 tx_dreq timing", tx_dreq, txe && !txe_p && txde_p);
      chk(rx_dreq == (rxf && !rxf_p && rxde_p), "R11 rx_dreq timing", rx_dreq, rxf && !rxf_p && rxde_p);
      chk(tx_irq == (txie_p && txe), "R12 tx_irq", tx_irq, txie_p && txe);
      chk(rx_irq == (rxie_p && (rxf || ovr)), "R12 rx_irq", rx_irq, rxie_p && (rxf || ovr));
      if (tx_dreq) txd_cnt++;
      if (rx_dreq) rxd_cnt++;
      if (busy_p && !busy) busy_falls++;
      if (sclk != sclk_p) begin
        if (meas) chk(ph == int'(cfg_div) + 1, "R3 half period", ph, int'(cfg_div) + 1);
        ph   = 1;
        meas = busy;
        if (sclk) begin
          mq.push_back(mosi);
          if (sq.size() > 0) void'(sq.pop_front());
        end
      end else if (busy && !busy_p) begin
        meas = 1'b1;
        ph   = 1;
      end else begin
        ph++;
      end
    end
    miso   = (sq.size() > 0) ? sq[0] : 1'b0;
    sclk_p = sclk; busy_p = busy; txe_p = txe; rxf_p = rxf;
    txde_p = tx_de; rxde_p = rx_de; txie_p = tx_ie; rxie_p = rx_ie;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_raw(input logic [MAXB-1:0] d);
    tx_data = d;
    tx_wr   = 1'b1;
    step();
    tx_wr   = 1'b0;
  endtask

  task automatic wr_wait(input logic [MAXB-1:0] d);
    while (!txe) step();
    wr_raw(d);
  endtask

  task automatic rd(output logic [MAXB-1:0] v);
    while (!rxf) step();
    v     = rx_data;
    rx_rd = 1'b1;
    step();
    rx_rd = 1'b0;
  endtask

  task automatic idle_wait();
    step();
    while (busy || !txe) step();
    repeat (3) step();
  endtask

  function automatic logic [MAXB-1:0] msk(input int len);
    return 16'hFFFF >> (MAXB - len);
  endfunction

  function automatic void push_word(input logic [MAXB-1:0] w, input int len, input bit lsb);
    for (int i = 0; i < len; i++) sq.push_back(lsb ? w[i] : w[len-1-i]);
  endfunction

  function automatic logic [MAXB-1:0] pull_word(input int len, input bit lsb);
    logic [MAXB-1:0] w = '0;
    for (int i = 0; i < len; i++) begin
      if (mq.size() == 0) return w;
      if (lsb) w[i] = mq.pop_front();
      else     w[len-1-i] = mq.pop_front();
    end
    return w;
  endfunction

  task automatic set_cfg(input int len, input int dv, input bit lsb);
    cfg_len = LW'(len);
    cfg_div = DW'(dv);
    cfg_lsb = lsb;
  endtask

  task automatic one_word(input string tag, input int len, input int dv, input bit lsb,
                          input logic [MAXB-1:0] txw, input logic [MAXB-1:0] sw);
    logic [MAXB-1:0] v;
    set_cfg(len, dv, lsb);
    mq.delete();
    push_word(sw, len, lsb);
    wr_wait(txw);
    rd(v);
    chk(v == (sw & msk(len)), {tag, " R6 received word"}, v, sw & msk(len));
    chk(!rxf, "R6 read clears rx_full", rxf, 0);
    idle_wait();
    chk(mq.size() == len, {tag, " R4 edge count"}, mq.size(), len);
    v = pull_word(len, lsb);
    chk(v == (txw & msk(len)), {tag, " R5 sent word"}, v, txw & msk(len));
  endtask

  initial begin
    logic [MAXB-1:0] v;
    int bf0, td0, rd0;
    repeat (4) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk(txe == 1'b1, "R1 tx_empty", txe, 1);
    chk(!rxf && !ovr, "R1 rx flags", {rxf, ovr}, 0);
    chk(!busy && !sclk, "R1 busy/sclk", {busy, sclk}, 0);
    chk(!tx_dreq && !rx_dreq && !tx_irq && !rx_irq, "R1 requests", {tx_dreq, rx_dreq, tx_irq, rx_irq}, 0);

    // R2 R4 R5 single words, several lengths and orders
    one_word("R2 dummy msb8",  8, 0, 1'b0, 16'h00A5, 16'h003C);
    one_word("R4 lsb16",      16, 1, 1'b1, 16'hBEEF, 16'h1234);
    one_word("R4 msb2",        2, 2, 1'b0, 16'hFFF2, 16'h0001);
    one_word("R5 lsb5",        5, 0, 1'b1, 16'h0013, 16'h0016);

    // R2 write while full is ignored
    set_cfg(8, 0, 1'b0);
    mq.delete();
    push_word(16'h0055, 8, 1'b0);
    wr_raw(16'h00C3);
    wr_raw(16'h0099);
    rd(v);
    idle_wait();
    chk(mq.size() == 8, "R2 only one word shifted", mq.size(), 8);
    v = pull_word(8, 1'b0);
    chk(v == 16'h00C3, "R2 ignored write not sent", v, 16'h00C3);

    // R8 continuous stream of three words
    set_cfg(8, 1, 1'b0);
    mq.delete();
    push_word(16'h0011, 8, 1'b0);
    push_word(16'h0022, 8, 1'b0);
    push_word(16'h0033, 8, 1'b0);
    bf0 = busy_falls;
    fork
      begin
        wr_wait(16'h00A1);
        wr_wait(16'h00B2);
        wr_wait(16'h00C3);
      end
      begin
        logic [MAXB-1:0] r;
        rd(r); chk(r == 16'h0011, "R8 rx word 1", r, 16'h0011);
        rd(r); chk(r == 16'h0022, "R8 rx word 2", r, 16'h0022);
        rd(r); chk(r == 16'h0033, "R8 rx word 3", r, 16'h0033);
      end
    join
    idle_wait();
    chk(busy_falls - bf0 == 1, "R8 no idle between words", busy_falls - bf0, 1);
    v = pull_word(8, 1'b0); chk(v == 16'h00A1, "R8 tx word 1", v, 16'h00A1);
    v = pull_word(8, 1'b0); chk(v == 16'h00B2, "R8 tx word 2", v, 16'h00B2);
    v = pull_word(8, 1'b0); chk(v == 16'h00C3, "R8 tx word 3", v, 16'h00C3);

    // R9 late write leaves an idle gap
    set_cfg(4, 0, 1'b0);
    mq.delete();
    push_word(16'h0009, 4, 1'b0);
    push_word(16'h0006, 4, 1'b0);
    bf0 = busy_falls;
    wr_wait(16'h0005);
    rd(v);
    chk(v == 16'h0009, "R9 first word", v, 16'h0009);
    repeat (4) begin
      step();
      chk(!busy && !sclk, "R9 bus idle in gap", {busy, sclk}, 0);
    end
    wr_wait(16'h000A);
    rd(v);
    chk(v == 16'h0006, "R9 second word", v, 16'h0006);
    idle_wait();
    chk(busy_falls - bf0 == 2, "R9 busy dropped between words", busy_falls - bf0, 2);

    // R7 overrun keeps the old word, R12 receive interrupt
    set_cfg(6, 0, 1'b0);
    rx_ie = 1'b1;
    mq.delete();
    push_word(16'h002B, 6, 1'b0);
    push_word(16'h0014, 6, 1'b0);
    wr_wait(16'h0001);
    wr_wait(16'h0002);
    idle_wait();
    chk(ovr == 1'b1, "R7 overrun set", ovr, 1);
    chk(rxf == 1'b1, "R7 rx_full still set", rxf, 1);
    chk(rx_data == 16'h002B, "R7 old word kept", rx_data, 16'h002B);
    chk(rx_irq == 1'b1, "R12 rx_irq raised", rx_irq, 1);
    rd(v);
    chk(!ovr && !rxf, "R7 read clears flags", {ovr, rxf}, 0);
    step();
    chk(rx_irq == 1'b0, "R12 rx_irq cleared", rx_irq, 0);
    rx_ie = 1'b0;

    // R10 R11 DMA request pulses, R12 transmit interrupt
    set_cfg(8, 0, 1'b1);
    tx_de = 1'b1; rx_de = 1'b1; tx_ie = 1'b1;
    mq.delete();
    push_word(16'h0081, 8, 1'b1);
    push_word(16'h0042, 8, 1'b1);
    td0 = txd_cnt; rd0 = rxd_cnt;
    fork
      begin
        wr_wait(16'h0018);
        wr_wait(16'h0024);
      end
      begin
        logic [MAXB-1:0] r;
        rd(r); chk(r == 16'h0081, "R11 dma rx word 1", r, 16'h0081);
        rd(r); chk(r == 16'h0042, "R11 dma rx word 2", r, 16'h0042);
      end
    join
    idle_wait();
    chk(txd_cnt - td0 == 2, "R10 tx_dreq pulses", txd_cnt - td0, 2);
    chk(rxd_cnt - rd0 == 2, "R11 rx_dreq pulses", rxd_cnt - rd0, 2);
    chk(tx_irq == 1'b1, "R12 tx_irq with empty buffer", tx_irq, 1);
    tx_de = 1'b0; rx_de = 1'b0;
    step();
    push_word(16'h0007, 8, 1'b1);
    td0 = txd_cnt; rd0 = rxd_cnt;
    wr_wait(16'h0070);
    rd(v);
    idle_wait();
    chk(txd_cnt == td0, "R10 no tx_dreq when disabled", txd_cnt - td0, 0);
    chk(rxd_cnt == rd0, "R11 no rx_dreq when disabled", rxd_cnt - rd0, 0);
    tx_ie = 1'b0;
    step();
    step();
    chk(tx_irq == 1'b0, "R12 tx_irq masked", tx_irq, 0);

    summary();
    $finish;
  end

endmodule